// File: doc/BRIEF.md
# Multi-Lane Test Pattern Generator

This block produces a stream of wide test words for checking the bandwidth and the data integrity of a memory path. Each word is cut into eight independent 64-bit lanes. Every lane keeps its own running value and its own increment, so the stream can be a plain counter, a set of counters with distinct strides, or a pattern that wraps at different rates per lane. A checker at the far end of the path can compute every word it should receive from the same seeds and increments.

A run is started with a one-cycle command that loads the lane seeds, the per-lane increments, the number of words to emit and the completed-block count carried over from the previous run. The block then emits that many words on a valid/ready stream. When the last word has been accepted it writes a status record. The record holds the incremented block count, a fixed marker code and the lane values that come after the last emitted word. Feeding that record back as the next seed lets a long test continue the sequence over many blocks with no break.

Top module: `lane_pattern_gen`

## Requirements
- R1: The output word holds lane i in bits [64*i+63 : 64*i] for lanes 0 to 7, and every lane is computed independently of the others.
- R2: The first word of a block equals the seed values loaded by the start command.
- R3: After each accepted word, each lane adds its own 64-bit increment to its value, wrapping modulo 2^64.
- R4: Lane values advance only on a cycle where out_valid and out_ready are both high; while out_ready is low the presented word is held unchanged.
- R5: A block emits exactly word_count words, after which out_valid stays low.
- R6: On completion, status_word0 bits [63:32] equal blk_count_in plus one.
- R7: On completion, status_word0 bits [15:0] equal the marker 0xAA56 and bits [31:16] are zero.
- R8: On completion, status_resume holds, per lane, the value that follows the last emitted word (seed plus word_count times increment).
- R9: A word_count of zero emits no word but still completes and increments the block count.
- R10: busy is high from the cycle after an accepted start until the status update is written, and a start while busy changes neither the stream nor the status.
- R11: After reset, busy and out_valid are low and both status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle command that loads the configuration and begins a block |
| seed_vec | input | 512 | Starting value of each lane |
| incr_vec | input | 512 | Increment of each lane |
| word_count | input | 32 | Number of words to emit in the block |
| blk_count_in | input | 32 | Completed-block count carried over from the last status record |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 512 | Output test word |
| busy | output | 1 | A block is running or its status update is pending |
| status_word0 | output | 64 | Block count in the upper half, marker code in the low 16 bits |
| status_resume | output | 512 | Lane values that follow the last emitted word |

## Verification
The start command is taken at the clock edge where it is seen, so busy and, for a non-empty block, the first word are due one cycle later. A word offered with out_ready high moves to the next value one edge after that. The status record and the fall of busy come two edges after the last accepted word, or two edges after a start with a zero count. The bench drives its inputs on the falling edge and samples just after it. It compares each word it sees accepted with the seed plus the accepted-word index times the increment. It reads the status only once busy has dropped, which is the first point at which the record is due.

// File: rtl/lane_pattern_pkg.sv
// Shared types and constants of the lane pattern generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lane_pattern_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_RUN  = 2'd1,
        PG_DONE = 2'd2
    } pg_state_t;

    localparam logic [15:0] PG_MARKER = 16'hAA56;

endpackage

// File: rtl/lane_pattern_lane.sv
// One lane of the generator: holds a running value and an increment.
// Loads seed and increment on load; adds the increment on step.
// Assumes load and step are never high together (the controller ensures it).
module lane_pattern_lane #(
    parameter int LANE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LANE_W-1:0] seed,
    input  logic [LANE_W-1:0] incr,
    output logic [LANE_W-1:0] value
);

    logic [LANE_W-1:0] incr_q;

    // Lane value and increment registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value  <= '0;
            incr_q <= '0;
        end else if (load) begin
            value  <= seed;
            incr_q <= incr;
        end else if (step) begin
            value  <= value + incr_q;
        end
    end

    // R2
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> value == $past(seed));

    // R4
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(value));

endmodule

// File: rtl/lane_pattern_ctrl.sv
// Block controller: accepts start when idle, counts accepted words,
// and spends one cycle in a completion state for the status update.
// Assumes word_count is sampled only at the accepted start.
module lane_pattern_ctrl
    import lane_pattern_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] word_count,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             load,
    output logic             step,
    output logic             done,
    output logic             busy
);

    pg_state_t        state;
    logic [CNT_W-1:0] remaining;

    // Decode of the control strobes from the state.
    always_comb begin
        load      = start && (state == PG_IDLE);
        out_valid = (state == PG_RUN);
        step      = out_valid && out_ready;
        done      = (state == PG_DONE);
        busy      = (state != PG_IDLE);
    end

    // State and remaining-word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PG_IDLE;
            remaining <= '0;
        end else begin
            case (state)
                PG_IDLE: if (start) begin
                    remaining <= word_count;
                    state     <= (word_count == '0) ? PG_DONE : PG_RUN;
                end
                PG_RUN: if (step) begin
                    remaining <= remaining - 1'b1;
                    if (remaining == CNT_W'(1)) state <= PG_DONE;
                end
                PG_DONE: state <= PG_IDLE;
                default: state <= PG_IDLE;
            endcase
        end
    end

    // R5
    valid_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> remaining != '0);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(remaining));

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done && !step) |=> $stable(remaining));

endmodule

// File: rtl/lane_pattern_status.sv
// Status record: block counter, marker word and resume lane values.
// Captures the incoming block count on load and writes the record on done.
// Assumes load and done are never high together.
module lane_pattern_status
    import lane_pattern_pkg::*;
#(
    parameter int BLK_W  = 32,
    parameter int DATA_W = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                done,
    input  logic [BLK_W-1:0]    blk_in,
    input  logic [DATA_W-1:0]   lanes,
    output logic [BLK_W+31:0]   word0,
    output logic [DATA_W-1:0]   resume
);

    logic [BLK_W-1:0] blk_q;

    // Block counter and status record registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            word0  <= '0;
            resume <= '0;
        end else if (load) begin
            blk_q  <= blk_in;
        end else if (done) begin
            blk_q  <= blk_q + 1'b1;
            word0  <= {blk_q + 1'b1, 16'h0000, PG_MARKER};
            resume <= lanes;
        end
    end

    // R7
    marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> word0[31:0] == {16'h0000, PG_MARKER});

    // R6
    blk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> word0[BLK_W+31:32] == $past(blk_q) + 1'b1);

    // R8
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> resume == $past(lanes));

endmodule

// File: rtl/lane_pattern_gen.sv
// Multi-lane test pattern generator top.
// Emits word_count words of LANES independent lanes on a valid/ready
// stream, then writes a resumable status record.
// Assumes start is ignored while busy and inputs are synchronous to clk.
module lane_pattern_gen
    import lane_pattern_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 64,
    parameter int CNT_W  = 32,
    parameter int BLK_W  = 32,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] seed_vec,
    input  logic [DATA_W-1:0] incr_vec,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [BLK_W-1:0]  blk_count_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              busy,
    output logic [BLK_W+31:0] status_word0,
    output logic [DATA_W-1:0] status_resume
);

    logic              load;
    logic              step;
    logic              done;
    logic [DATA_W-1:0] lane_vals;

    lane_pattern_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_count (word_count),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .load       (load),
        .step       (step),
        .done       (done),
        .busy       (busy)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_pattern_lane #(.LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .step  (step),
            .seed  (seed_vec[i*LANE_W +: LANE_W]),
            .incr  (incr_vec[i*LANE_W +: LANE_W]),
            .value (lane_vals[i*LANE_W +: LANE_W])
        );
    end

    lane_pattern_status #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .done   (done),
        .blk_in (blk_count_in),
        .lanes  (lane_vals),
        .word0  (status_word0),
        .resume (status_resume)
    );

    // The stream presents the lane registers directly.
    always_comb out_data = lane_vals;

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

    // R5
    no_valid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid);

endmodule

// File: tb/sim_lane_pattern_gen.sv
// Directed bench for lane_pattern_gen: one task per scenario.
module sim_lane_pattern_gen;

    localparam int LANES  = 8;
    localparam int LW     = 64;
    localparam int DW     = LANES * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] seed_vec = '0;
    logic [DW-1:0] incr_vec = '0;
    logic [31:0]   word_count = '0;
    logic [31:0]   blk_count_in = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          busy;
    logic [63:0]   status_word0;
    logic [DW-1:0] status_resume;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    lane_pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .seed_vec(seed_vec), .incr_vec(incr_vec),
        .word_count(word_count), .blk_count_in(blk_count_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy), .status_word0(status_word0), .status_resume(status_resume)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [DW-1:0] expect_word(input logic [DW-1:0] s,
                                                  input logic [DW-1:0] inc,
                                                  input logic [63:0] k);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*LW +: LW] = s[i*LW +: LW] + k * inc[i*LW +: LW];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one block. mode: 0 ready always, 1 alternating, 2 stalled 4 cycles.
    // disturb issues a second start with other values while busy.
    task automatic run_block(input logic [DW-1:0] s, input logic [DW-1:0] inc,
                             input int n, input logic [31:0] blk, input int mode,
                             input bit disturb, input string tag);
        int k = 0;
        int c = 0;
        bit bad_word = 0;
        logic [DW-1:0] first_bad = '0;
        logic [DW-1:0] first_exp = '0;
        @(negedge clk);
        seed_vec = s; incr_vec = inc; word_count = n; blk_count_in = blk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: busy due one cycle after the accepted start
        check(busy == 1'b1, {tag, " R10 busy after start"}, DW'(busy), DW'(1));
        while (1) begin
            if (disturb && c == 2) begin
                start = 1'b1; seed_vec = ~s; word_count = n + 3; blk_count_in = blk + 50;
            end else begin
                start = 1'b0;
            end
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = c[0];
                default: out_ready = (c >= 4);
            endcase
            #1;
            if (!busy) break;
            if (out_valid && out_ready) begin
                // R1 R2 R3 R4: accepted word k equals seed + k*incr per lane
                if (out_data !== expect_word(s, inc, 64'(k)) && !bad_word) begin
                    bad_word = 1;
                    first_bad = out_data;
                    first_exp = expect_word(s, inc, 64'(k));
                end
                k++;
            end
            c++;
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;
        seed_vec = s;
        check(!bad_word, {tag, " R1 R2 R3 R4 word values"}, first_bad, first_exp);
        // R5: exactly n words accepted
        check(k == n, {tag, " R5 word count"}, DW'(k), DW'(n));
        // R6: block count incremented
        check(status_word0[63:32] == blk + 1, {tag, " R6 block count"},
              DW'(status_word0[63:32]), DW'(blk + 1));
        // R7: marker code
        check(status_word0[31:0] == 32'h0000AA56, {tag, " R7 marker"},
              DW'(status_word0[31:0]), DW'(32'h0000AA56));
        // R8: resume values
        check(status_resume == expect_word(s, inc, 64'(n)), {tag, " R8 resume"},
              status_resume, expect_word(s, inc, 64'(n)));
    endtask

    task automatic t_reset();
        // R11: reset state
        check(!busy && !out_valid, "R11 idle after reset", DW'({busy, out_valid}), '0);
        check(status_word0 == '0 && status_resume == '0, "R11 status cleared",
              DW'(status_word0), '0);
    endtask

    function automatic logic [DW-1:0] fill(input logic [63:0] base, input logic [63:0] step);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*LW +: LW] = base + 64'(i) * step;
        return r;
    endfunction

    task automatic t_basic();
        run_block(fill(64'h100, 64'h1000), fill(64'd1, 64'd1), 5, 32'd0, 0, 0, "basic");
    endtask

    task automatic t_wrap_backpressure();
        run_block(fill(64'hFFFF_FFFF_FFFF_FFF0, 64'h3), fill(64'h7FFF_FFFF_FFFF_FFFF, 64'h11),
                  7, 32'd9, 1, 0, "wrap");
    endtask

    task automatic t_resume();
        logic [DW-1:0] s0 = fill(64'hABC, 64'h55);
        logic [DW-1:0] inc = fill(64'd3, 64'd2);
        run_block(s0, inc, 4, 32'd100, 0, 0, "resume-a");
        // continue from the record: equivalent to one 10-word block
        run_block(status_resume, inc, 6, status_word0[63:32], 1, 0, "resume-b");
        check(status_resume == expect_word(s0, inc, 64'd10), "R8 seamless resume",
              status_resume, expect_word(s0, inc, 64'd10));
        check(status_word0[63:32] == 32'd102, "R6 two blocks",
              DW'(status_word0[63:32]), DW'(102));
    endtask

    task automatic t_zero();
        int seen = 0;
        @(negedge clk);
        seed_vec = fill(64'h77, 64'h1); incr_vec = fill(64'h5, 64'h0);
        word_count = 0; blk_count_in = 32'hFFFF_FFFF; out_ready = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy on zero count", DW'(busy), DW'(1));
        for (int i = 0; i < 6; i++) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        // R9: no word emitted, count wraps to zero, resume equals seed
        check(seen == 0, "R9 no word for zero count", DW'(seen), '0);
        check(status_word0 == 64'h0000_0000_0000_AA56, "R9 count increments",
              DW'(status_word0), DW'(64'h0000_0000_0000_AA56));
        check(status_resume == fill(64'h77, 64'h1), "R9 resume is seed",
              status_resume, fill(64'h77, 64'h1));
    endtask

    task automatic t_start_busy();
        // R10: second start while stalled must not disturb the block
        run_block(fill(64'h4000, 64'h10), fill(64'h9, 64'h4), 4, 32'd7, 2, 1, "busy-start");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_wrap_backpressure();
        t_resume();
        t_zero();
        t_start_busy();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule